// File: doc/BRIEF.md
# Vector Length Setting Unit

This block carries out the instruction that sizes the vector engine in a design where vectors are laid over the ordinary scalar register file. A caller presents one 32-bit instruction word together with a strobe, plus the count register value and the data from one general-purpose read port. The unit supplies the read address for that port from the instruction itself. It then works out a new maximum vector length (MVL) and a new vector length (VL) and stores both.

The block also keeps the vertical-first flag. It can write VL back to a destination register, and it can produce a zero flag for the condition field. The requested length can come from the count register, from a general register, from a one-based immediate, or from the present VL. The result is always clamped to MVL, and MVL itself may be loaded from the same immediate.

The step-advance encoding is not executed here. It is recognised and handed to the stepping logic. Malformed words are reported as illegal. Every accepted word yields a one-cycle done pulse on the cycle after it is presented.

Top module: `vl_set_unit`

## Requirements
- R1: The word is legal only when instrWord[31:26] equals 22 and instrWord[5:1] equals 5'b11110. Any other word pulses `illegal` and leaves VL, MVL, the vertical-first flag and both write strobes untouched.
- R2: Every cycle with `startValid` high is followed on the next cycle by a one-cycle `doneValid` pulse, whatever the word holds.
- R3: The immediate field instrWord[15:10] is one-based: 0 stands for a length of 1 and 63 stands for 64.
- R4: When the VL-set flag instrWord[7] is high, the requested VL is chosen in this priority order: the count register when instrWord[9] is high; otherwise the general register addressed by RA (instrWord[20:16]) when RA is nonzero; otherwise the one-based immediate. `gprAddr` always presents RA combinationally.
- R5: When instrWord[7] is low, the requested VL is the current VL state.
- R6: When the MVL-set flag instrWord[8] is high, MVL takes the one-based immediate. Otherwise MVL keeps its value, so MVL never exceeds 64.
- R7: The new VL is the smaller of the request and the new MVL, compared at the full 64-bit width, so large count or register values saturate to MVL.
- R8: The new VL, zero-extended, is written to destination RT (instrWord[25:21]) with `rtWriteEn` only when RT is nonzero.
- R9: When instrWord[0] is high, `crWriteEn` pulses and `crEq` is 1 exactly when the new VL is 0.
- R10: Every legal, non-step execution loads the vertical-first state with instrWord[6].
- R11: A legal word with instrWord[6]=1, instrWord[7]=0 and instrWord[8]=0 pulses `stepReq` instead, and changes no state and writes nothing.
- R12: After reset, VL, MVL and the vertical-first flag are 0 and all output strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Instruction word present this cycle |
| instrWord | input | 32 | Instruction word |
| ctrValue | input | 64 | Count register value |
| gprData | input | 64 | Data from the general register at gprAddr |
| gprAddr | output | 5 | RA field, read address for the register port |
| doneValid | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Word did not decode as this instruction |
| stepReq | output | 1 | Step-advance encoding forwarded to stepping logic |
| rtWriteEn | output | 1 | Destination register write strobe |
| rtAddr | output | 5 | Destination register number |
| rtData | output | 64 | Value written to the destination (new VL) |
| crWriteEn | output | 1 | Condition field write strobe |
| crEq | output | 1 | Equal bit: new VL is zero |
| vlState | output | 7 | Current VL |
| mvlState | output | 7 | Current MVL |
| vfState | output | 1 | Current vertical-first flag |

## Verification
The cases hardest to reach are a VL of zero and a clamp on a huge operand. VL can only become zero through a zero count or general-register value, or by keeping a zero VL from reset, because the immediate never gives zero. Saturation needs a 64-bit operand far above 127 while MVL is small. The stimulus therefore steers most random count and register values into a handful of buckets: exact zero, values near MVL, and full-width values. It interleaves MVL changes so that a clamp against a recently lowered MVL is exercised often. Directed words add the kept-VL path and the step and illegal encodings, and they confirm that state stays fixed across those words.

// File: rtl/vl_set_pkg.sv
package vl_set_pkg;

  // Field layout of the instruction word, most significant bit first.
  typedef struct packed {
    logic [5:0] opcd;
    logic [4:0] rt;
    logic [4:0] ra;
    logic [5:0] imm;
    logic       cv;
    logic       ms;
    logic       vs;
    logic       vf;
    logic [4:0] sub;
    logic       rc;
  } svlFields_t;

  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_COUNT = 2'd1,
    SRC_GPR   = 2'd2,
    SRC_IMM   = 2'd3
  } vlSrc_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   loadState;
    logic   loadMvl;
    vlSrc_t vlSrc;
    logic   writeRt;
    logic   writeCr;
  } svlStrobes_t;

endpackage

// File: rtl/vl_set_clamp.sv
module vl_set_clamp #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic [XLEN-1:0]  reqValue,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] clamped
);
  logic [XLEN-1:0] limitWide;

  always_comb begin
    limitWide = XLEN'(limit);
    if (reqValue > limitWide) clamped = limit;
    else                      clamped = reqValue[LEN_W-1:0];
  end
endmodule

// File: rtl/vl_set_ctrl.sv
module vl_set_ctrl
  import vl_set_pkg::*;
#(
  parameter logic [5:0] OPCODE = 6'd22,
  parameter logic [4:0] SUBOP  = 5'b11110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startValid,
  input  logic [31:0] instrWord,
  output svlFields_t  fields,
  output svlStrobes_t strobes,
  output logic [4:0]  gprAddr,
  output logic        doneValid,
  output logic        illegal,
  output logic        stepReq
);
  logic opOk;
  logic isStep;
  logic execNow;

  always_comb begin
    fields  = svlFields_t'(instrWord);
    gprAddr = fields.ra;
    opOk    = (fields.opcd == OPCODE) && (fields.sub == SUBOP);
    isStep  = fields.vf && !fields.vs && !fields.ms;
    execNow = startValid && opOk && !isStep;

    strobes.loadState = execNow;
    strobes.loadMvl   = fields.ms;
    strobes.writeRt   = execNow && (fields.rt != 5'd0);
    strobes.writeCr   = execNow && fields.rc;
    if (!fields.vs)               strobes.vlSrc = SRC_KEEP;
    else if (fields.cv)           strobes.vlSrc = SRC_COUNT;
    else if (fields.ra != 5'd0)   strobes.vlSrc = SRC_GPR;
    else                          strobes.vlSrc = SRC_IMM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneValid <= 1'b0;
      illegal   <= 1'b0;
      stepReq   <= 1'b0;
    end else begin
      doneValid <= startValid;
      illegal   <= startValid && !opOk;
      stepReq   <= startValid && opOk && isStep;
    end
  end
endmodule

// File: rtl/vl_set_dp.sv
module vl_set_dp
  import vl_set_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  svlFields_t       fields,
  input  svlStrobes_t      strobes,
  input  logic [XLEN-1:0]  ctrValue,
  input  logic [XLEN-1:0]  gprData,
  output logic             rtWriteEn,
  output logic [4:0]       rtAddr,
  output logic [XLEN-1:0]  rtData,
  output logic             crWriteEn,
  output logic             crEq,
  output logic [LEN_W-1:0] vlState,
  output logic [LEN_W-1:0] mvlState,
  output logic             vfState
);
  logic [LEN_W-1:0] immLen;
  logic [XLEN-1:0]  reqWide;
  logic [LEN_W-1:0] mvlNext;
  logic [LEN_W-1:0] vlNext;

  always_comb begin
    immLen  = LEN_W'(fields.imm) + LEN_W'(1);
    mvlNext = strobes.loadMvl ? immLen : mvlState;
    unique case (strobes.vlSrc)
      SRC_COUNT: reqWide = ctrValue;
      SRC_GPR:   reqWide = gprData;
      SRC_IMM:   reqWide = XLEN'(immLen);
      default:   reqWide = XLEN'(vlState);
    endcase
  end

  vl_set_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
    .reqValue (reqWide),
    .limit    (mvlNext),
    .clamped  (vlNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlState  <= '0;
      mvlState <= '0;
      vfState  <= 1'b0;
    end else if (strobes.loadState) begin
      vlState  <= vlNext;
      mvlState <= mvlNext;
      vfState  <= fields.vf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtWriteEn <= 1'b0;
      rtAddr    <= '0;
      rtData    <= '0;
      crWriteEn <= 1'b0;
      crEq      <= 1'b0;
    end else begin
      rtWriteEn <= strobes.writeRt;
      rtAddr    <= fields.rt;
      rtData    <= XLEN'(vlNext);
      crWriteEn <= strobes.writeCr;
      crEq      <= strobes.writeCr && (vlNext == '0);
    end
  end
endmodule

// File: rtl/vl_set_unit.sv
module vl_set_unit
  import vl_set_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startValid,
  input  logic [31:0]      instrWord,
  input  logic [XLEN-1:0]  ctrValue,
  input  logic [XLEN-1:0]  gprData,
  output logic [4:0]       gprAddr,
  output logic             doneValid,
  output logic             illegal,
  output logic             stepReq,
  output logic             rtWriteEn,
  output logic [4:0]       rtAddr,
  output logic [XLEN-1:0]  rtData,
  output logic             crWriteEn,
  output logic             crEq,
  output logic [LEN_W-1:0] vlState,
  output logic [LEN_W-1:0] mvlState,
  output logic             vfState
);
  svlFields_t  fields;
  svlStrobes_t strobes;

  vl_set_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .instrWord  (instrWord),
    .fields     (fields),
    .strobes    (strobes),
    .gprAddr    (gprAddr),
    .doneValid  (doneValid),
    .illegal    (illegal),
    .stepReq    (stepReq)
  );

  vl_set_dp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fields    (fields),
    .strobes   (strobes),
    .ctrValue  (ctrValue),
    .gprData   (gprData),
    .rtWriteEn (rtWriteEn),
    .rtAddr    (rtAddr),
    .rtData    (rtData),
    .crWriteEn (crWriteEn),
    .crEq      (crEq),
    .vlState   (vlState),
    .mvlState  (mvlState),
    .vfState   (vfState)
  );
endmodule

// File: rtl/vl_set_unit_chk.sv
module vl_set_unit_chk #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startValid,
  input logic             doneValid,
  input logic             illegal,
  input logic             stepReq,
  input logic             rtWriteEn,
  input logic [4:0]       rtAddr,
  input logic [XLEN-1:0]  rtData,
  input logic             crWriteEn,
  input logic             crEq,
  input logic [LEN_W-1:0] vlState,
  input logic [LEN_W-1:0] mvlState,
  input logic             vfState
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(64);

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startValid |=> doneValid);

  // R1
  illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (vlState == $past(vlState) && mvlState == $past(mvlState) &&
                 vfState == $past(vfState) && !rtWriteEn && !crWriteEn));

  // R11
  step_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepReq |-> (vlState == $past(vlState) && mvlState == $past(mvlState) &&
                 vfState == $past(vfState) && !rtWriteEn && !crWriteEn));

  // R1
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, stepReq, rtWriteEn | crWriteEn}));

  // R7
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlState <= mvlState);

  // R6
  mvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mvlState <= MAX_LEN);

  // R8
  rt_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtWriteEn |-> (rtAddr != 5'd0 && rtData == XLEN'(vlState)));

  // R9
  cr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crWriteEn |-> (crEq == (vlState == '0)));

  // R9
  cr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crWriteEn |-> !crEq);
endmodule

bind vl_set_unit vl_set_unit_chk #(.XLEN(XLEN), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/vl_set_unit_bench.sv
`timescale 1ns/1ps
module vl_set_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] ctrValue = '0;
  logic [63:0] gprData = '0;
  logic [4:0]  gprAddr;
  logic        doneValid, illegal, stepReq, rtWriteEn, crWriteEn, crEq, vfState;
  logic [4:0]  rtAddr;
  logic [63:0] rtData;
  logic [6:0]  vlState, mvlState;

  int total = 0;
  int bad = 0;

  // Bench model of the state
  logic [6:0] mVl = '0, mMvl = '0;
  logic       mVf = 1'b0;

  always #2.5 clk = ~clk;

  vl_set_unit u_vl_set_unit (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] ra,
      input logic [5:0] imm, input logic cv, input logic ms, input logic vs,
      input logic vf, input logic rc);
    return {6'd22, rt, ra, imm, cv, ms, vs, vf, 5'b11110, rc};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] ctr, input logic [63:0] gpr);
    logic legal, stp, eRtWe, eCrWe, eCrEq;
    logic [6:0] imm1, eMvl, eVl;
    logic [63:0] req;
    legal = (w[31:26] == 6'd22) && (w[5:1] == 5'b11110);
    stp   = legal && w[6] && !w[7] && !w[8];
    eRtWe = 1'b0; eCrWe = 1'b0; eCrEq = 1'b0; eVl = mVl; eMvl = mMvl;
    if (legal && !stp) begin
      imm1 = {1'b0, w[15:10]} + 7'd1;
      if (!w[7])                req = {57'd0, mVl};
      else if (w[9])            req = ctr;
      else if (w[20:16] != 5'd0) req = gpr;
      else                      req = {57'd0, imm1};
      eMvl  = w[8] ? imm1 : mMvl;
      eVl   = (req > {57'd0, eMvl}) ? eMvl : req[6:0];
      eRtWe = (w[25:21] != 5'd0);
      eCrWe = w[0];
      eCrEq = w[0] && (eVl == 7'd0);
      mVl = eVl; mMvl = eMvl; mVf = w[6];
    end
    @(negedge clk);
    startValid = 1'b1; instrWord = w; ctrValue = ctr; gprData = gpr;
    #1;
    chk("R4 gprAddr", {59'd0, gprAddr}, {59'd0, w[20:16]});
    @(posedge clk);
    #1 startValid = 1'b0;
    @(negedge clk);
    chk("R2 doneValid", {63'd0, doneValid}, 64'd1);
    chk("R1 illegal", {63'd0, illegal}, {63'd0, !legal});
    chk("R11 stepReq", {63'd0, stepReq}, {63'd0, stp});
    chk("R7 vlState", {57'd0, vlState}, {57'd0, mVl});
    chk("R6 mvlState", {57'd0, mvlState}, {57'd0, mMvl});
    chk("R10 vfState", {63'd0, vfState}, {63'd0, mVf});
    chk("R8 rtWriteEn", {63'd0, rtWriteEn}, {63'd0, eRtWe});
    if (eRtWe) begin
      chk("R8 rtAddr", {59'd0, rtAddr}, {59'd0, w[25:21]});
      chk("R8 rtData", rtData, {57'd0, eVl});
    end
    chk("R9 crWriteEn", {63'd0, crWriteEn}, {63'd0, eCrWe});
    chk("R9 crEq", {63'd0, crEq}, {63'd0, eCrEq});
  endtask

  function automatic logic [63:0] pickVal(input int sel);
    case (sel % 4)
      0:       return 64'd0;
      1:       return 64'($urandom % 80);
      2:       return {$urandom, $urandom};
      default: return 64'(60 + $urandom % 10);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 vlState", {57'd0, vlState}, 64'd0);
    chk("R12 mvlState", {57'd0, mvlState}, 64'd0);
    chk("R12 vfState", {63'd0, vfState}, 64'd0);
    chk("R12 strobes", {58'd0, doneValid, illegal, stepReq, rtWriteEn, crWriteEn, crEq}, 64'd0);
    rst_n = 1'b1;

    // Set MVL to 8, VL kept at 0 from reset
    issue(mk(5'd0, 5'd0, 6'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1), 64'd0, 64'd0);
    chk("R6 mvl from imm", {57'd0, mvlState}, 64'd8);
    chk("R5 vl kept", {57'd0, vlState}, 64'd0);
    // VL from immediate 7 -> 8
    issue(mk(5'd3, 5'd0, 6'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0), 64'd0, 64'd0);
    chk("R3 imm plus one", {57'd0, vlState}, 64'd8);
    // Both from immediate 63 -> 64
    issue(mk(5'd3, 5'd0, 6'd63, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0), 64'd0, 64'd0);
    chk("R3 imm max", {57'd0, vlState}, 64'd64);
    // Huge GPR saturates to MVL
    issue(mk(5'd3, 5'd5, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0), 64'd0, 64'hFFFF_0000_0000_0001);
    chk("R7 saturate", {57'd0, vlState}, 64'd64);
    // Count wins over RA
    issue(mk(5'd3, 5'd5, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), 64'd3, 64'd40);
    chk("R4 count priority", {57'd0, vlState}, 64'd3);
    // Lower MVL to 2, VL kept request 3 -> 2
    issue(mk(5'd0, 5'd0, 6'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 64'd0, 64'd0);
    chk("R5 kept then clamped", {57'd0, vlState}, 64'd2);
    // Zero from GPR with Rc
    issue(mk(5'd4, 5'd5, 6'd9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1), 64'd7, 64'd0);
    chk("R9 zero VL", {63'd0, crEq}, 64'd1);
    // Vertical-first set
    issue(mk(5'd0, 5'd0, 6'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0), 64'd0, 64'd0);
    chk("R10 vf loaded", {63'd0, vfState}, 64'd1);
    // Step encoding
    issue(mk(5'd7, 5'd0, 6'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1), 64'd0, 64'd0);
    chk("R11 step state", {57'd0, vlState}, 64'd4);
    // Illegal opcode
    issue({6'd31, mk(5'd7, 5'd0, 6'd10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1)[25:0]}, 64'd0, 64'd0);
    chk("R1 illegal state", {57'd0, mvlState}, 64'd4);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = mk(5'($urandom), ($urandom % 3 == 0) ? 5'd0 : 5'($urandom),
             6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom));
      if ($urandom % 12 == 0) w[31:26] = 6'($urandom);
      if ($urandom % 12 == 0) w[5:1]   = 5'($urandom);
      issue(w, pickVal(int'($urandom)), pickVal(int'($urandom)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule